// File: doc/BRIEF.md
# Glitch-Free Switchable Clock Prescaler

This block divides a fast input clock by a power of two chosen at runtime. It emits a one-cycle enable pulse, `tick`, once per divided period. The CPU and every synchronous peripheral qualify their registers with this pulse, so they all advance together at the divided rate. The counter that sets the period runs on the undivided input clock.

Software changes the rate with a two-step byte write. A first write with the key bit set opens a short acceptance window. A second write, with the key bit clear, carries the new exponent. The new exponent is held as pending and `busy` goes high. The running period always completes at its old length. At that period's final pulse the counter restarts from zero with the new factor, so the first new period is full length. As a result, every period on the output is exactly one old period or one new period, and never a runt.

Top module: `sysclk_prescaler`

## Requirements
- R1: After reset, `rate_code` is 0, `busy` is low and `tick` is high on every input cycle (division by 1).
- R2: With exponent N in effect, `tick` is high for exactly one input cycle out of every 2^N, and `rate_code` presents N.
- R3: A write whose bit 7 is 1 is a key write. A write whose bit 7 is 0 is a value write. A value write made 1 to 4 input cycles after a key write is accepted, takes its exponent from bits 6:0, and makes `busy` high in the following cycle.
- R4: A value write with no key write 1 to 4 cycles earlier is ignored, as is a second value write after the window has already been used. Neither sets `busy` nor changes the rate.
- R5: An accepted exponent above 8 is treated as 8.
- R6: A pending exponent takes effect only at a `tick`. Periods up to and including that pulse keep the old length, and the counter restarts from zero with the new factor after it. A value write landing in a `tick` cycle waits for the next one.
- R7: Every interval between consecutive pulses equals 2^N for the exponent shown on `rate_code` at the closing pulse. No interval is shorter than both the old and the new period.
- R8: `busy` stays high from the cycle after an accepted write until the cycle after the `tick` that applies it. `busy` never falls except right after a `tick`.
- R9: An accepted write made while `busy` replaces the pending exponent. The replaced value never appears on `rate_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_strobe | input | 1 | Setting write strobe, one cycle per write |
| wr_data | input | 8 | Write byte: bit 7 = key, bits 6:0 = exponent |
| tick | output | 1 | One-cycle enable pulse per divided period |
| busy | output | 1 | A new exponent is pending |
| rate_code | output | 4 | Exponent N currently in effect |

## Verification
The hardest situation to reach from the ports is a value write that lands exactly in the cycle of a `tick`, while a slow rate is running. The stimulus waits for an observed pulse and then counts out the known period, so that the key write falls one cycle before the next pulse and the value write falls on it. A second hard case is replacing a pending value during a 256-cycle period. The bench makes two accepted writes a few cycles apart and records every exponent seen on `rate_code` until `busy` drops. A behavioural model tracks the remaining cycles in each period and is compared with all three outputs on every cycle.

// File: rtl/prescaler_pkg.sv
// Shared constants and types for the switchable clock prescaler.
// Assumes a single clock domain; all widths derive from these defaults.
package prescaler_pkg;
    localparam int PS_MAX_SHIFT  = 8;   // largest exponent, factor 2^8
    localparam int PS_DATA_W     = 8;   // width of the write byte
    localparam int PS_KEY_BIT    = 7;   // bit that marks a key write
    localparam int PS_WIN_CYCLES = 4;   // cycles a key write stays valid

    // Classification of one write cycle on the setting interface.
    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_KEY   = 2'd1,
        WR_VALUE = 2'd2
    } wr_kind_e;
endpackage

// File: rtl/presc_unlock_guard.sv
// Decodes setting writes and enforces the key-then-value sequence.
// A key write opens a window of WIN_CYCLES cycles; one value write in that
// window is accepted and closes it. The exponent field is clamped.
// Assumes wr_strobe is a single-cycle pulse per write.
module presc_unlock_guard
    import prescaler_pkg::*;
#(
    parameter int DATA_W     = PS_DATA_W,
    parameter int KEY_BIT    = PS_KEY_BIT,
    parameter int WIN_CYCLES = PS_WIN_CYCLES,
    parameter int MAX_SHIFT  = PS_MAX_SHIFT,
    parameter int RATE_W     = $clog2(MAX_SHIFT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_data,
    output logic              load_en,
    output logic [RATE_W-1:0] load_code
);
    localparam int FIELD_W = KEY_BIT;
    localparam int WIN_W   = $clog2(WIN_CYCLES + 1);

    wr_kind_e             kind;
    logic [WIN_W-1:0]     win_q;
    logic [FIELD_W-1:0]   field;

    // Classify the current write cycle.
    always_comb begin
        if (!wr_strobe)              kind = WR_IDLE;
        else if (wr_data[KEY_BIT])   kind = WR_KEY;
        else                         kind = WR_VALUE;
    end

    // Extract and clamp the exponent field.
    always_comb begin
        field = wr_data[FIELD_W-1:0];
        if (int'(field) > MAX_SHIFT) load_code = RATE_W'(MAX_SHIFT);
        else                         load_code = RATE_W'(field);
    end

    assign load_en = (kind == WR_VALUE) && (win_q != '0);

    // Window countdown: reload on a key, close on acceptance, else decay.
    always_ff @(posedge clk) begin
        if (!rst_n)                 win_q <= '0;
        else if (kind == WR_KEY)    win_q <= WIN_W'(WIN_CYCLES);
        else if (load_en)           win_q <= '0;
        else if (win_q != '0)       win_q <= win_q - 1'b1;
    end
endmodule

// File: rtl/presc_rate_reg.sv
// Holds the exponent in effect and the pending one awaiting handover.
// The pending value moves into effect only on a period-end pulse, which
// guarantees every period is a whole old or a whole new period.
// Assumes tick comes from the divider running on the active exponent.
module presc_rate_reg #(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_en,
    input  logic [RATE_W-1:0] load_code,
    output logic [RATE_W-1:0] rate,
    output logic              busy
);
    logic [RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] pend_q;
    logic              pend_v;

    // Active exponent: adopt the pending value at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)              rate_q <= '0;
        else if (tick && pend_v) rate_q <= pend_q;
    end

    // Pending slot: a new write always wins; a handover empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0;
            pend_q <= '0;
        end else if (load_en) begin
            pend_v <= 1'b1;
            pend_q <= load_code;
        end else if (tick) begin
            pend_v <= 1'b0;
        end
    end

    assign rate = rate_q;
    assign busy = pend_v;
endmodule

// File: rtl/presc_div_counter.sv
// Free-running period counter on the undivided clock. The period is
// 2^rate cycles; tick marks its last cycle. The counter returns to zero
// after every tick, so a rate change applied at tick starts a full period.
// Assumes rate changes only in the cycle after a tick.
module presc_div_counter #(
    parameter int MAX_SHIFT = 8,
    parameter int RATE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    // Terminal count: the low 'rate' bits set.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            last[i] = (i < int'(rate));
        end
    end

    assign tick = (cnt_q == last);

    // Count up, wrap to zero at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sysclk_prescaler.sv
// Top of the switchable power-of-two clock prescaler. Produces a period
// enable pulse for the whole synchronous domain, accepts rate changes
// through a key-protected byte write, and hands them over at a period end.
// Assumes one clock and a synchronous active-low reset.
module sysclk_prescaler
    import prescaler_pkg::*;
#(
    parameter int  DATA_W     = PS_DATA_W,
    parameter int  KEY_BIT    = PS_KEY_BIT,
    parameter int  WIN_CYCLES = PS_WIN_CYCLES,
    parameter int  MAX_SHIFT  = PS_MAX_SHIFT,
    localparam int RATE_W     = $clog2(MAX_SHIFT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tick,
    output logic              busy,
    output logic [RATE_W-1:0] rate_code
);
    logic              load_en;
    logic [RATE_W-1:0] load_code;
    logic [RATE_W-1:0] rate;

    presc_unlock_guard #(
        .DATA_W     (DATA_W),
        .KEY_BIT    (KEY_BIT),
        .WIN_CYCLES (WIN_CYCLES),
        .MAX_SHIFT  (MAX_SHIFT),
        .RATE_W     (RATE_W)
    ) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .load_en   (load_en),
        .load_code (load_code)
    );

    presc_rate_reg #(
        .RATE_W (RATE_W)
    ) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load_en   (load_en),
        .load_code (load_code),
        .rate      (rate),
        .busy      (busy)
    );

    presc_div_counter #(
        .MAX_SHIFT (MAX_SHIFT),
        .RATE_W    (RATE_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .rate  (rate),
        .tick  (tick)
    );

    assign rate_code = rate;
endmodule

// File: rtl/prescaler_checker.sv
// Temporal checks for sysclk_prescaler, attached by bind. Keeps its own
// window tracker and pulse-gap counter, independent of the design's state.
module prescaler_checker #(
    parameter int MAX_SHIFT  = 8,
    parameter int RATE_W     = 4,
    parameter int WIN_CYCLES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key_wr,
    input logic              val_wr,
    input logic              tick,
    input logic              busy,
    input logic [RATE_W-1:0] rate_code
);
    localparam int SU_W  = $clog2(WIN_CYCLES + 2);
    localparam int GAP_W = MAX_SHIFT + 2;

    logic [SU_W-1:0]  since_key;
    logic [GAP_W-1:0] gap;
    logic             open_win;

    assign open_win = (since_key != '0) && (int'(since_key) <= WIN_CYCLES);

    // Cycles since the last key write, saturating once the window is gone.
    always_ff @(posedge clk) begin
        if (!rst_n)                       since_key <= SU_W'(WIN_CYCLES + 1);
        else if (key_wr)                  since_key <= SU_W'(1);
        else if (val_wr && open_win)      since_key <= SU_W'(WIN_CYCLES + 1);
        else if (int'(since_key) <= WIN_CYCLES) since_key <= since_key + 1'b1;
    end

    // Cycles elapsed since the previous pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    gap <= '0;
        else if (tick) gap <= '0;
        else           gap <= gap + 1'b1;
    end

    // R3: an accepted value write raises busy next cycle
    a_r3_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && open_win) |=> busy);

    // R4: a value write outside the window leaves an idle block idle
    a_r4_reject_keeps_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && !open_win && !busy) |=> !busy);

    // R5: exponent never exceeds the maximum
    a_r5_rate_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rate_code) <= MAX_SHIFT);

    // R6: the exponent only moves right after a period end
    a_r6_rate_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_code) |-> $past(tick));

    // R7: each pulse closes a period of exactly 2^rate cycles
    a_r7_period_length: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ((int'(gap) + 1) == (1 << rate_code)));

    // R8: busy only drops right after a period end
    a_r8_busy_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick));
endmodule

bind sysclk_prescaler prescaler_checker #(
    .MAX_SHIFT  (MAX_SHIFT),
    .RATE_W     (RATE_W),
    .WIN_CYCLES (WIN_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_wr    (wr_strobe && wr_data[KEY_BIT]),
    .val_wr    (wr_strobe && !wr_data[KEY_BIT]),
    .tick      (tick),
    .busy      (busy),
    .rate_code (rate_code)
);

// File: tb/sysclk_prescaler_tb.sv
// Bench for sysclk_prescaler: behavioural model compared every cycle,
// plus directed checks on the write sequence, clamping and handover.
module sysclk_prescaler_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick;
    logic       busy;
    logic [3:0] rate_code;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Reference model state
    int m_rate = 0;
    int m_left = 1;
    int m_pv   = 0;
    int m_pend = 0;
    int m_win  = 0;
    int gap    = 0;

    always #4 clk = ~clk;

    sysclk_prescaler u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .tick      (tick),
        .busy      (busy),
        .rate_code (rate_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int clampc(input int v);
        return (v > 8) ? 8 : v;
    endfunction

    // Model: cycles left in the period, pending slot, key window.
    always @(posedge clk) begin : model
        bit acc;
        if (!rst_n) begin
            m_rate = 0; m_left = 1; m_pv = 0; m_pend = 0; m_win = 0;
        end else begin
            acc = wr_strobe && !wr_data[7] && (m_win > 0);
            if (m_left == 1) begin
                if (m_pv != 0) begin
                    m_rate = m_pend;
                    m_pv = 0;
                end
                m_left = 1 << m_rate;
            end else begin
                m_left = m_left - 1;
            end
            if (acc) begin
                m_pv = 1;
                m_pend = clampc(int'(wr_data[6:0]));
            end
            if (wr_strobe && wr_data[7]) m_win = 4;
            else if (acc)                m_win = 0;
            else if (m_win > 0)          m_win = m_win - 1;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            gap = 0;
        end else if (!done) begin
            chk("R2 R6 tick", int'(tick), int'(m_left == 1));
            chk("R8 busy", int'(busy), m_pv);
            chk("R2 rate_code", int'(rate_code), m_rate);
            gap++;
            if (tick) begin
                chk("R7 period length", gap, 1 << m_rate);
                gap = 0;
            end
        end
    end

    task automatic put(input logic [7:0] b);
        wr_strobe = 1'b1;
        wr_data   = b;
        @(negedge clk);
        wr_strobe = 1'b0;
        wr_data   = 8'h00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle(output int seen);
        seen = 0;
        while (busy) begin
            seen |= (1 << rate_code);
            @(negedge clk);
        end
        seen |= (1 << rate_code);
    endtask

    initial begin : main
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset rate", int'(rate_code), 0);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset tick", int'(tick), 1);
        idle(4);

        // R3: key then value on the next cycle
        put(8'h80); put(8'h02);
        chk("R3 busy after accept", int'(busy), 1);
        wait_idle(seen); idle(2);
        chk("R3 rate applied", int'(rate_code), 2);

        // R4: value write with no key
        put(8'h03);
        chk("R4 lone write busy", int'(busy), 0);
        idle(12);
        chk("R4 lone write rate", int'(rate_code), 2);

        // R4: value write five cycles after the key
        put(8'h80); idle(4); put(8'h05);
        chk("R4 late write busy", int'(busy), 0);

        // R3: value write four cycles after the key, then R4 reuse of window
        put(8'h80); idle(3); put(8'h05);
        chk("R3 window edge busy", int'(busy), 1);
        put(8'h07);
        wait_idle(seen); idle(2);
        chk("R4 window used once", int'(rate_code), 5);

        // R5: clamp 12 to 8
        put(8'h80); put(8'h0C);
        wait_idle(seen);
        chk("R5 clamp 12", int'(rate_code), 8);

        // R9: replace a pending value during a 256-cycle period
        put(8'h80); put(8'h01); idle(3); put(8'h80); put(8'h03);
        wait_idle(seen); idle(2);
        chk("R9 final rate", int'(rate_code), 3);
        chk("R9 replaced value never applied", (seen >> 1) & 1, 0);

        // R6: value write landing in a tick cycle at rate 3
        while (!tick) @(negedge clk);
        idle(7);
        put(8'h80);
        chk("R6 aligned tick", int'(tick), 1);
        put(8'h06);
        chk("R6 waits a full old period busy", int'(busy), 1);
        chk("R6 waits a full old period rate", int'(rate_code), 3);
        wait_idle(seen);
        chk("R6 new rate", int'(rate_code), 6);

        // R7: slow to fast and back through the largest field value
        put(8'h80); put(8'h00);
        wait_idle(seen);
        chk("R7 fast rate", int'(rate_code), 0);
        put(8'h80); put(8'h7F);
        wait_idle(seen);
        chk("R5 clamp 127", int'(rate_code), 8);
        put(8'h80); put(8'h00);
        wait_idle(seen);
        chk("R7 back to fast", int'(rate_code), 0);
        idle(20);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        done = 1'b1;
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule